// File: doc/BRIEF.md
# DMA Channel Control Register File

This block holds the software-visible settings of one DMA channel in a packet network interface. A bus master programs an outgoing transfer by writing a destination endpoint, a source pointer, a short header payload and finally a byte count. Writing the byte count also launches the transfer. An incoming transfer is set up the same way: software writes a buffer base pointer, a buffer length in words and a start index, and then writes a receive-control word that launches the receive engine.

The block also packs engine activity, interrupt enables and sticky interrupt status into one 14-bit flag word, and drives one interrupt line for the channel. The receive buffer is handled as a ring. For each incoming data word the block computes the write address, wrapping back to the base pointer at the end of the ring, and it marks words past the ring length for discarding. When that happens it raises an overflow status.

The register offsets are: 1 flags, 2 destination, 3 send pointer, 4 send byte count, 5 header payload, 9 receive pointer, 11 receive buffer length, 12 receive start index, 13 receive control. A write to any other offset changes nothing.

Top module: `dma_chan_regs`

## Requirements
- R1: While reset is asserted and after it is released, every programmed field, both start pulses, the flag word (apart from the busy and got-packet mirrors of the inputs) and the interrupt are zero.
- R2: A write takes effect only when `sel_i`, `stb_i` and `we_i` are all high. Offset 2 loads `dest_o` from the low 8 data bits, offset 3 loads `tx_ptr_o`, offset 5 loads `hdr_o` from the low 16 bits, offset 9 loads `rx_ptr_o`, offset 11 loads `rx_buf_o` and offset 12 loads `rx_idx_o` from the low 10 bits. Other offsets leave these fields unchanged.
- R3: A write to offset 4 while `tx_busy_i` is low loads `tx_len_o` from the low 12 bits and pulses `tx_start_o` for exactly the following cycle. The same write while `tx_busy_i` is high gives no pulse, leaves `tx_len_o` unchanged and sets flag bit 13 (rejected request).
- R4: A write to offset 13 with data bit 0 set while `rx_busy_i` is low pulses `rx_start_o` for the following cycle. When `rx_busy_i` is high, or data bit 0 is clear, there is no pulse.
- R5: Flag word bits 5, 4, 3 and 2 are the enables for error, got-packet, packet-saved and packet-sent. A flags write (offset 1) loads them directly from the same data bits.
- R6: Status bits are sticky. Bit 12 is set by `ev_burst_err_i`, bit 11 by `ev_len_err_i`, bit 10 by `ev_crc_err_i`, bit 7 by `ev_saved_i` and bit 6 by `ev_sent_i`. Each of the bits 13..9, 7 and 6 is cleared by a flags write with a 1 at that position. An event in the same cycle as its clear wins.
- R7: Flag bit 8 (got packet) equals `hdr_at_head_i` AND NOT `rx_busy_i` in every cycle. It is not sticky, and a flags write does not clear it.
- R8: `irq_o` is (bit 5 AND any of bits 13..9) OR (bit 4 AND bit 8) OR (bit 3 AND bit 7) OR (bit 2 AND bit 6).
- R9: For a data word index i below the buffer length L, with start index s below L, `rx_wr_addr_o` is the receive pointer plus 4 times ((s+i) mod L), and `rx_wr_keep_o` is high. When i is L or more, `rx_wr_keep_o` is low.
- R10: A data word with `rx_word_vld_i` high and index i of at least L sets flag bit 9 (buffer overflow) from the next cycle.
- R11: Flag bit 0 mirrors `tx_busy_i` and flag bit 1 mirrors `rx_busy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sel_i | input | 1 | Channel select from the address decode |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Bus write enable |
| ofs_i | input | 4 | Register offset within the channel |
| wdata_i | input | 32 | Write data |
| tx_busy_i | input | 1 | Send engine busy |
| rx_busy_i | input | 1 | Receive engine busy |
| hdr_at_head_i | input | 1 | Header flit waiting at the head of the input queue |
| ev_sent_i | input | 1 | Pulse: packet sent |
| ev_saved_i | input | 1 | Pulse: packet saved |
| ev_crc_err_i | input | 1 | Pulse: CRC mismatch |
| ev_len_err_i | input | 1 | Pulse: send size error |
| ev_burst_err_i | input | 1 | Pulse: burst size error |
| rx_word_vld_i | input | 1 | A received data word is being stored |
| rx_word_idx_i | input | 10 | Index of that word within the packet |
| dest_o | output | 8 | Destination endpoint |
| tx_ptr_o | output | 32 | Send source pointer (bytes) |
| tx_len_o | output | 12 | Send byte count |
| hdr_o | output | 16 | Header payload |
| rx_ptr_o | output | 32 | Receive ring base (bytes) |
| rx_buf_o | output | 10 | Receive ring length (words) |
| rx_idx_o | output | 10 | Receive start index (words) |
| tx_start_o | output | 1 | One-cycle send launch |
| rx_start_o | output | 1 | One-cycle receive launch |
| rx_wr_addr_o | output | 32 | Byte address for the current received word |
| rx_wr_keep_o | output | 1 | Current received word fits in the ring |
| flags_o | output | 14 | Packed flag word |
| irq_o | output | 1 | Channel interrupt |

## Verification
Two things can reach the same sticky status bit in one cycle: an engine event that sets it and a software flags write that clears it. The stimulus raises event pulses at random together with flags writes that carry random clear masks. Some directed steps also put a packet-sent event and its own clear in the same cycle. The bench's model applies the clear first and the set after it, so the bit must read 1 on the next cycle and return to 0 only after a later clear with no event.

A second coincidence is a send byte-count write while the send engine reports busy. The bench drives it both at random and in a directed step. It is judged on the missing launch pulse, the unchanged byte count and the rejected-request bit.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [3:0] {
    OFS_FLAGS = 4'd1,
    OFS_DEST  = 4'd2,
    OFS_TXPTR = 4'd3,
    OFS_TXLEN = 4'd4,
    OFS_HDR   = 4'd5,
    OFS_RXPTR = 4'd9,
    OFS_RXBUF = 4'd11,
    OFS_RXIDX = 4'd12,
    OFS_RXCTL = 4'd13
  } reg_ofs_e;

  typedef struct packed {
    logic flags;
    logic dest;
    logic txptr;
    logic txlen;
    logic hdr;
    logic rxptr;
    logic rxbuf;
    logic rxidx;
    logic rxctl;
  } wr_hit_t;

  localparam int FLAG_W = 14;

  localparam int FB_TXBUSY   = 0;
  localparam int FB_RXBUSY   = 1;
  localparam int FB_EN_SENT  = 2;
  localparam int FB_EN_SAVED = 3;
  localparam int FB_EN_GOT   = 4;
  localparam int FB_EN_ERR   = 5;
  localparam int FB_SENT     = 6;
  localparam int FB_SAVED    = 7;
  localparam int FB_GOT      = 8;
  localparam int FB_OVFL     = 9;
  localparam int FB_CRC      = 10;
  localparam int FB_LEN      = 11;
  localparam int FB_BURST    = 12;
  localparam int FB_BADREQ   = 13;

  // sticky, write-one-to-clear positions
  localparam logic [FLAG_W-1:0] STICKY_MASK = 14'b11111011000000;

endpackage

// File: rtl/dma_chan_wr_decode.sv
module dma_chan_wr_decode
  import dma_chan_pkg::*;
(
  input  logic       sel_i,
  input  logic       stb_i,
  input  logic       we_i,
  input  logic [3:0] ofs_i,
  output wr_hit_t    hit_o
);

  logic wr_en;
  assign wr_en = sel_i & stb_i & we_i;

  always_comb begin
    hit_o = '0;
    if (wr_en) begin
      case (ofs_i)
        OFS_FLAGS: hit_o.flags = 1'b1;
        OFS_DEST:  hit_o.dest  = 1'b1;
        OFS_TXPTR: hit_o.txptr = 1'b1;
        OFS_TXLEN: hit_o.txlen = 1'b1;
        OFS_HDR:   hit_o.hdr   = 1'b1;
        OFS_RXPTR: hit_o.rxptr = 1'b1;
        OFS_RXBUF: hit_o.rxbuf = 1'b1;
        OFS_RXIDX: hit_o.rxidx = 1'b1;
        OFS_RXCTL: hit_o.rxctl = 1'b1;
        default:   hit_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_tx_regs.sv
module dma_chan_tx_regs
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EA_W   = 8,
  parameter int PTR_W  = 32,
  parameter int LEN_W  = 12,
  parameter int HDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_hit_t           hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic [EA_W-1:0]   dest_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [HDR_W-1:0]  hdr_o,
  output logic              start_o,
  output logic              bad_req_o
);

  logic [EA_W-1:0]  dest_q, dest_n;
  logic [PTR_W-1:0] ptr_q,  ptr_n;
  logic [LEN_W-1:0] len_q,  len_n;
  logic [HDR_W-1:0] hdr_q,  hdr_n;
  logic             start_q, start_n;
  logic             launch;

  assign launch    = hit_i.txlen & ~busy_i;
  assign bad_req_o = hit_i.txlen &  busy_i;

  always_comb begin
    dest_n  = dest_q;
    ptr_n   = ptr_q;
    len_n   = len_q;
    hdr_n   = hdr_q;
    start_n = launch;
    if (hit_i.dest)  dest_n = wdata_i[EA_W-1:0];
    if (hit_i.txptr) ptr_n  = wdata_i[PTR_W-1:0];
    if (launch)      len_n  = wdata_i[LEN_W-1:0];
    if (hit_i.hdr)   hdr_n  = wdata_i[HDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q  <= '0;
      ptr_q   <= '0;
      len_q   <= '0;
      hdr_q   <= '0;
      start_q <= 1'b0;
    end else begin
      dest_q  <= dest_n;
      ptr_q   <= ptr_n;
      len_q   <= len_n;
      hdr_q   <= hdr_n;
      start_q <= start_n;
    end
  end

  assign dest_o  = dest_q;
  assign ptr_o   = ptr_q;
  assign len_o   = len_q;
  assign hdr_o   = hdr_q;
  assign start_o = start_q;

  // R3: a launch only ever follows an idle engine
  a_r3_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(busy_i));

  // R3: a rejected request keeps the programmed count
  a_r3_busy_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i.txlen && busy_i) |=> $stable(len_o));

endmodule

// File: rtl/dma_chan_rx_regs.sv
module dma_chan_rx_regs
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32,
  parameter int BUF_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_hit_t           hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              word_vld_i,
  input  logic [BUF_W-1:0]  word_idx_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [BUF_W-1:0]  buf_o,
  output logic [BUF_W-1:0]  idx_o,
  output logic              start_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic              keep_o,
  output logic              ovfl_o
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = (BYTES > 1) ? $clog2(BYTES) : 0;

  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [BUF_W-1:0] buf_q, buf_n;
  logic [BUF_W-1:0] idx_q, idx_n;
  logic             start_q, start_n;

  logic [BUF_W:0]   pos_sum;
  logic [BUF_W:0]   pos_wrap;
  logic [PTR_W-1:0] pos_bytes;

  always_comb begin
    ptr_n   = ptr_q;
    buf_n   = buf_q;
    idx_n   = idx_q;
    start_n = hit_i.rxctl & wdata_i[0] & ~busy_i;
    if (hit_i.rxptr) ptr_n = wdata_i[PTR_W-1:0];
    if (hit_i.rxbuf) buf_n = wdata_i[BUF_W-1:0];
    if (hit_i.rxidx) idx_n = wdata_i[BUF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      buf_q   <= '0;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_n;
      buf_q   <= buf_n;
      idx_q   <= idx_n;
      start_q <= start_n;
    end
  end

  // ring position: start index plus word index, folded once at the ring end
  always_comb begin
    pos_sum  = {1'b0, idx_q} + {1'b0, word_idx_i};
    pos_wrap = (pos_sum >= {1'b0, buf_q}) ? (pos_sum - {1'b0, buf_q}) : pos_sum;
    pos_bytes = {{(PTR_W-BUF_W){1'b0}}, pos_wrap[BUF_W-1:0]} << OFS_W;
  end

  assign wr_addr_o = ptr_q + pos_bytes;
  assign keep_o    = (word_idx_i < buf_q);
  assign ovfl_o    = word_vld_i & ~keep_o;

  assign ptr_o   = ptr_q;
  assign buf_o   = buf_q;
  assign idx_o   = idx_q;
  assign start_o = start_q;

  logic [PTR_W-1:0] addr_off;
  logic [PTR_W-1:0] ring_bytes;
  assign addr_off   = wr_addr_o - ptr_o;
  assign ring_bytes = {{(PTR_W-BUF_W){1'b0}}, buf_o} << OFS_W;

  // R9: a kept word always lands inside the ring
  a_r9_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_o && (idx_o < buf_o)) |-> (addr_off < ring_bytes));

  // R4: receive launch only after an idle engine
  a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(busy_i));

endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wflags_i,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  input  logic              hdr_at_head_i,
  input  logic              ev_sent_i,
  input  logic              ev_saved_i,
  input  logic              ev_crc_i,
  input  logic              ev_len_i,
  input  logic              ev_burst_i,
  input  logic              bad_req_i,
  input  logic              ovfl_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);

  logic [FLAG_W-1:0] stat_q, stat_n;
  logic [FLAG_W-1:0] set_v, clr_v;
  logic [3:0]        en_q, en_n;
  logic              got_pkt;
  logic              any_err;

  always_comb begin
    set_v             = '0;
    set_v[FB_BADREQ]  = bad_req_i;
    set_v[FB_BURST]   = ev_burst_i;
    set_v[FB_LEN]     = ev_len_i;
    set_v[FB_CRC]     = ev_crc_i;
    set_v[FB_OVFL]    = ovfl_i;
    set_v[FB_SAVED]   = ev_saved_i;
    set_v[FB_SENT]    = ev_sent_i;
    clr_v  = wr_i ? (wflags_i & STICKY_MASK) : '0;
    stat_n = ((stat_q & ~clr_v) | set_v) & STICKY_MASK;
    en_n   = wr_i ? wflags_i[FB_EN_ERR:FB_EN_SENT] : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_n;
      en_q   <= en_n;
    end
  end

  assign got_pkt = hdr_at_head_i & ~rx_busy_i;
  assign any_err = |stat_q[FB_BADREQ:FB_OVFL];

  always_comb begin
    flags_o                         = stat_q;
    flags_o[FB_GOT]                 = got_pkt;
    flags_o[FB_EN_ERR:FB_EN_SENT]   = en_q;
    flags_o[FB_RXBUSY]              = rx_busy_i;
    flags_o[FB_TXBUSY]              = tx_busy_i;
  end

  assign irq_o = (en_q[3] & any_err) | (en_q[2] & got_pkt) |
                 (en_q[1] & stat_q[FB_SAVED]) | (en_q[0] & stat_q[FB_SENT]);

  // R8: no interrupt while every enable is clear
  a_r8_quiet_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[FB_EN_ERR:FB_EN_SENT] == 4'd0) |-> !irq_o);

  // R6: an event wins over a same-cycle clear
  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sent_i |=> flags_o[FB_SENT]);

  // R6: a clear without an event empties the bit
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wflags_i[FB_SAVED] && !ev_saved_i) |=> !flags_o[FB_SAVED]);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EA_W   = 8,
  parameter int PTR_W  = 32,
  parameter int LEN_W  = 12,
  parameter int HDR_W  = 16,
  parameter int BUF_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [3:0]        ofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  input  logic              hdr_at_head_i,
  input  logic              ev_sent_i,
  input  logic              ev_saved_i,
  input  logic              ev_crc_err_i,
  input  logic              ev_len_err_i,
  input  logic              ev_burst_err_i,
  input  logic              rx_word_vld_i,
  input  logic [BUF_W-1:0]  rx_word_idx_i,
  output logic [EA_W-1:0]   dest_o,
  output logic [PTR_W-1:0]  tx_ptr_o,
  output logic [LEN_W-1:0]  tx_len_o,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [PTR_W-1:0]  rx_ptr_o,
  output logic [BUF_W-1:0]  rx_buf_o,
  output logic [BUF_W-1:0]  rx_idx_o,
  output logic              tx_start_o,
  output logic              rx_start_o,
  output logic [PTR_W-1:0]  rx_wr_addr_o,
  output logic              rx_wr_keep_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);

  wr_hit_t hit;
  logic    bad_req;
  logic    ovfl;

  dma_chan_wr_decode u_dec (
    .sel_i (sel_i),
    .stb_i (stb_i),
    .we_i  (we_i),
    .ofs_i (ofs_i),
    .hit_o (hit)
  );

  dma_chan_tx_regs #(
    .DATA_W (DATA_W),
    .EA_W   (EA_W),
    .PTR_W  (PTR_W),
    .LEN_W  (LEN_W),
    .HDR_W  (HDR_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit),
    .wdata_i   (wdata_i),
    .busy_i    (tx_busy_i),
    .dest_o    (dest_o),
    .ptr_o     (tx_ptr_o),
    .len_o     (tx_len_o),
    .hdr_o     (hdr_o),
    .start_o   (tx_start_o),
    .bad_req_o (bad_req)
  );

  dma_chan_rx_regs #(
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W),
    .BUF_W  (BUF_W)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .wdata_i    (wdata_i),
    .busy_i     (rx_busy_i),
    .word_vld_i (rx_word_vld_i),
    .word_idx_i (rx_word_idx_i),
    .ptr_o      (rx_ptr_o),
    .buf_o      (rx_buf_o),
    .idx_o      (rx_idx_o),
    .start_o    (rx_start_o),
    .wr_addr_o  (rx_wr_addr_o),
    .keep_o     (rx_wr_keep_o),
    .ovfl_o     (ovfl)
  );

  dma_chan_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (hit.flags),
    .wflags_i      (wdata_i[FLAG_W-1:0]),
    .tx_busy_i     (tx_busy_i),
    .rx_busy_i     (rx_busy_i),
    .hdr_at_head_i (hdr_at_head_i),
    .ev_sent_i     (ev_sent_i),
    .ev_saved_i    (ev_saved_i),
    .ev_crc_i      (ev_crc_err_i),
    .ev_len_i      (ev_len_err_i),
    .ev_burst_i    (ev_burst_err_i),
    .bad_req_i     (bad_req),
    .ovfl_i        (ovfl),
    .flags_o       (flags_o),
    .irq_o         (irq_o)
  );

  // R2: an unselected channel keeps its destination
  a_r2_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> $stable(dest_o));

  // R3: a count write to a busy engine raises the rejected-request bit
  a_r3_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && stb_i && we_i && (ofs_i == 4'd4) && tx_busy_i) |=> flags_o[FB_BADREQ]);

  // R10: a word beyond the ring raises the overflow bit
  a_r10_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_vld_i && !rx_wr_keep_o) |=> flags_o[FB_OVFL]);

endmodule

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, stb, we;
  logic [3:0]  ofs;
  logic [31:0] wdata;
  logic        tx_busy, rx_busy, hdr_head;
  logic        ev_sent, ev_saved, ev_crc, ev_len, ev_burst;
  logic        wvld;
  logic [9:0]  widx;
  logic [7:0]  dest;
  logic [31:0] tx_ptr, rx_ptr, rx_addr;
  logic [11:0] tx_len;
  logic [15:0] hdr;
  logic [9:0]  rx_buf, rx_idx;
  logic        tx_start, rx_start, rx_keep, irq;
  logic [13:0] flags;

  always #2.5 clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .stb_i(stb), .we_i(we), .ofs_i(ofs),
    .wdata_i(wdata), .tx_busy_i(tx_busy), .rx_busy_i(rx_busy), .hdr_at_head_i(hdr_head),
    .ev_sent_i(ev_sent), .ev_saved_i(ev_saved), .ev_crc_err_i(ev_crc),
    .ev_len_err_i(ev_len), .ev_burst_err_i(ev_burst), .rx_word_vld_i(wvld),
    .rx_word_idx_i(widx), .dest_o(dest), .tx_ptr_o(tx_ptr), .tx_len_o(tx_len),
    .hdr_o(hdr), .rx_ptr_o(rx_ptr), .rx_buf_o(rx_buf), .rx_idx_o(rx_idx),
    .tx_start_o(tx_start), .rx_start_o(rx_start), .rx_wr_addr_o(rx_addr),
    .rx_wr_keep_o(rx_keep), .flags_o(flags), .irq_o(irq)
  );

  // reference state
  logic [7:0]  m_dest;
  logic [31:0] m_txptr, m_rxptr;
  logic [11:0] m_txlen;
  logic [15:0] m_hdr;
  logic [9:0]  m_rxbuf, m_rxidx;
  logic [13:0] m_st;
  logic [3:0]  m_en;
  logic        m_txs, m_rxs;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [13:0] CLR_BITS = (14'd1 << 13) | (14'd1 << 12) | (14'd1 << 11) |
                                     (14'd1 << 10) | (14'd1 << 9) | (14'd1 << 7) | (14'd1 << 6);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_got();
    return hdr_head & ~rx_busy;
  endfunction

  function automatic logic [13:0] exp_flags();
    logic [13:0] f;
    f = m_st & CLR_BITS;
    f[8] = exp_got();
    f[5:2] = m_en;
    f[1] = rx_busy;
    f[0] = tx_busy;
    return f;
  endfunction

  function automatic logic exp_irq();
    return (m_en[3] & (|m_st[13:9])) | (m_en[2] & exp_got()) |
           (m_en[1] & m_st[7]) | (m_en[0] & m_st[6]);
  endfunction

  function automatic logic [31:0] exp_addr();
    int pos;
    pos = int'(m_rxidx) + int'(widx);
    if (pos >= int'(m_rxbuf)) pos = pos - int'(m_rxbuf);
    return m_rxptr + 32'(pos * 4);
  endfunction

  task automatic check_all();
    chk("R1/R2 dest", {56'd0, dest}, {56'd0, m_dest});
    chk("R2 tx_ptr", {32'd0, tx_ptr}, {32'd0, m_txptr});
    chk("R3 tx_len", {52'd0, tx_len}, {52'd0, m_txlen});
    chk("R2 hdr", {48'd0, hdr}, {48'd0, m_hdr});
    chk("R2 rx_ptr", {32'd0, rx_ptr}, {32'd0, m_rxptr});
    chk("R2 rx_buf", {54'd0, rx_buf}, {54'd0, m_rxbuf});
    chk("R2 rx_idx", {54'd0, rx_idx}, {54'd0, m_rxidx});
    chk("R3 tx_start", {63'd0, tx_start}, {63'd0, m_txs});
    chk("R4 rx_start", {63'd0, rx_start}, {63'd0, m_rxs});
    chk("R6 status", {50'd0, flags & CLR_BITS & ~(14'd1 << 9)},
        {50'd0, exp_flags() & CLR_BITS & ~(14'd1 << 9)});
    chk("R10 overflow", {63'd0, flags[9]}, {63'd0, m_st[9]});
    chk("R5 enables", {60'd0, flags[5:2]}, {60'd0, m_en});
    chk("R7 got", {63'd0, flags[8]}, {63'd0, exp_got()});
    chk("R11 busy", {62'd0, flags[1:0]}, {62'd0, rx_busy, tx_busy});
    chk("R8 irq", {63'd0, irq}, {63'd0, exp_irq()});
    chk("R9 keep", {63'd0, rx_keep}, {63'd0, (widx < m_rxbuf)});
    if ((widx < m_rxbuf) && (m_rxidx < m_rxbuf))
      chk("R9 addr", {32'd0, rx_addr}, {32'd0, exp_addr()});
  endtask

  // one clock: update the model from the driven inputs, then compare
  task automatic step();
    logic wr;
    logic [13:0] setv, clrv;
    wr = sel & stb & we;
    setv = '0;
    setv[13] = wr && ofs == 4'd4 && tx_busy;
    setv[12] = ev_burst;
    setv[11] = ev_len;
    setv[10] = ev_crc;
    setv[9]  = wvld && (widx >= m_rxbuf);
    setv[7]  = ev_saved;
    setv[6]  = ev_sent;
    clrv = (wr && ofs == 4'd1) ? (wdata[13:0] & CLR_BITS) : '0;
    m_txs = wr && ofs == 4'd4 && !tx_busy;
    m_rxs = wr && ofs == 4'd13 && wdata[0] && !rx_busy;
    if (wr) begin
      case (ofs)
        4'd1:  m_en = wdata[5:2];
        4'd2:  m_dest = wdata[7:0];
        4'd3:  m_txptr = wdata;
        4'd4:  if (!tx_busy) m_txlen = wdata[11:0];
        4'd5:  m_hdr = wdata[15:0];
        4'd9:  m_rxptr = wdata;
        4'd11: m_rxbuf = wdata[9:0];
        4'd12: m_rxidx = wdata[9:0];
        default: ;
      endcase
    end
    m_st = ((m_st & ~clrv) | setv) & CLR_BITS;
    @(negedge clk);
    check_all();
    sel = 0; stb = 0; we = 0; ev_sent = 0; ev_saved = 0;
    ev_crc = 0; ev_len = 0; ev_burst = 0; wvld = 0;
  endtask

  task automatic wr_reg(input logic [3:0] o, input logic [31:0] d);
    sel = 1; stb = 1; we = 1; ofs = o; wdata = d;
    step();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; sel = 0; stb = 0; we = 0; ofs = 0; wdata = 0;
    tx_busy = 0; rx_busy = 0; hdr_head = 0;
    ev_sent = 0; ev_saved = 0; ev_crc = 0; ev_len = 0; ev_burst = 0;
    wvld = 0; widx = 0;
    m_dest = 0; m_txptr = 0; m_rxptr = 0; m_txlen = 0; m_hdr = 0;
    m_rxbuf = 0; m_rxidx = 0; m_st = 0; m_en = 0; m_txs = 0; m_rxs = 0;
    repeat (3) @(negedge clk);
    // R1: reset values, with a write attempted during reset
    sel = 1; stb = 1; we = 1; ofs = 4'd2; wdata = 32'hFF;
    @(negedge clk);
    check_all();
    sel = 0; stb = 0; we = 0;
    rst_n = 1;
    @(negedge clk);
    check_all();

    // R2: unselected write ignored
    stb = 1; we = 1; ofs = 4'd2; wdata = 32'h5A; sel = 0;
    step();
    // R3: count write while idle, then while busy
    wr_reg(4'd4, 32'h0000_0123);
    tx_busy = 1;
    wr_reg(4'd4, 32'h0000_0456);
    tx_busy = 0;
    // R4: receive launch variants
    wr_reg(4'd13, 32'h1);
    wr_reg(4'd13, 32'h0);
    rx_busy = 1; wr_reg(4'd13, 32'h1); rx_busy = 0;
    // R9/R10: ring of 8 words, start index 5
    wr_reg(4'd9, 32'h0000_1000);
    wr_reg(4'd11, 32'd8);
    wr_reg(4'd12, 32'd5);
    for (int i = 0; i < 10; i++) begin
      wvld = 1; widx = 10'(i);
      step();
    end
    // R6: sent event in the same cycle as its clear; then a clear alone
    ev_sent = 1; step();
    wr_reg(4'd1, 32'h0000_0040 | 32'h4);
    ev_sent = 1; sel = 1; stb = 1; we = 1; ofs = 4'd1; wdata = 32'h0000_0044;
    step();
    wr_reg(4'd1, 32'h0000_0044);
    // R8/R7: got-packet interrupt
    hdr_head = 1; wr_reg(4'd1, 32'h0000_0010);
    rx_busy = 1; step(); rx_busy = 0; hdr_head = 0;
    wr_reg(4'd1, 32'h3FFF);

    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      int pick;
      logic [3:0] offs [10];
      offs = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9, 4'd11, 4'd12, 4'd13, 4'd7};
      tx_busy  = ($urandom % 3) == 0;
      rx_busy  = ($urandom % 3) == 0;
      hdr_head = ($urandom % 2) == 0;
      ev_sent  = ($urandom % 8) == 0;
      ev_saved = ($urandom % 8) == 0;
      ev_crc   = ($urandom % 20) == 0;
      ev_len   = ($urandom % 20) == 0;
      ev_burst = ($urandom % 20) == 0;
      wvld = ($urandom % 4) == 0;
      widx = (m_rxbuf != 0) ? 10'($urandom % (32'(m_rxbuf) + 3)) : 10'($urandom % 4);
      if (($urandom % 3) != 0) begin
        pick = int'($urandom % 10);
        sel = ($urandom % 10) != 0; stb = 1; we = ($urandom % 8) != 0;
        ofs = offs[pick];
        wdata = $urandom;
        if (ofs == 4'd11) wdata = 32'(1 + ($urandom % 600));
        if (ofs == 4'd12) wdata = (m_rxbuf != 0) ? ($urandom % 32'(m_rxbuf)) : 32'd0;
      end
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule